// File: doc/BRIEF.md
# Sprite XOR Blitter

This block paints an 8-pixel-wide monochrome sprite into a 64 by 32 one-bit frame buffer that it holds internally. A drawing command supplies a screen position, a row count and the main-memory address of the sprite's first byte. The block fetches one byte per row over a request/valid handshake. It XORs each byte into the buffer row it lands on and then pulses a completion strobe. The strobe carries a flag that tells whether any lit pixel was turned dark. Because pixels are toggled rather than overwritten, drawing the same sprite twice in the same place removes it again. The collision flag is what a game uses to detect that two objects touched.

A display read port returns any whole buffer row combinationally from the committed contents. A clear command wipes the whole picture in one cycle. Each buffer row is one register word, so a fetched row is read, modified and written back in the single cycle in which its byte arrives.

Top module: `sprite_blitter`

## Requirements
- R1: After reset, busy, done, collision and memReq are 0 and every frame buffer bit is 0.
- R2: An accepted start (startCmd high while idle and clearCmd low) raises busy in the next cycle. Busy stays high up to and including the single cycle in which done is high. With a memory that answers in the request cycle, done comes height+1 cycles after the start cycle.
- R3: While waiting for a row byte, memReq is high and memAddr holds (baseAddr + row index) modulo 4096. Both stay unchanged until memValid is seen, and rows are fetched in order 0, 1, 2, and so on.
- R4: Bit 7 of a row byte lands on column X and bit 7-k on column X+k. Each set bit inverts the pixel it lands on, and clear bits leave pixels unchanged.
- R5: X is posX modulo 64, and a column past 63 wraps to column (X+k) modulo 64 of the same row.
- R6: Y is posY modulo 32, and sprite row i lands on buffer row (Y+i) modulo 32.
- R7: In the done cycle, collision is 1 exactly when the draw turned some buffer bit from 1 to 0. In every other cycle it is 0.
- R8: A height of 0 gives done in the cycle after the start cycle, with no memory request and an unchanged buffer.
- R9: A startCmd that arrives while busy is ignored and does not alter the position, the height or the drawing in progress.
- R10: clearCmd while idle sets all 2048 bits to 0 in the next cycle and wins over a startCmd in the same cycle, which is then ignored. clearCmd while busy is ignored.
- R11: dispData returns buffer row dispRow combinationally, with bit c of dispData being column c.
- R12: Drawing a sprite a second time at the same place and height restores the buffer to its prior contents and reports collision 1 whenever the sprite has any set bit on the screen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startCmd | input | 1 | Begin a draw with the values on posX, posY, height and baseAddr |
| clearCmd | input | 1 | Zero the whole frame buffer |
| posX | input | 8 | Horizontal position, used modulo 64 |
| posY | input | 8 | Vertical position, used modulo 32 |
| height | input | 4 | Number of sprite rows, 0 to 15 |
| baseAddr | input | 12 | Memory address of the first sprite byte |
| memReq | output | 1 | Row byte request |
| memAddr | output | 12 | Address of the requested byte |
| memValid | input | 1 | The requested byte is on memData |
| memData | input | 8 | Sprite row byte, bit 7 is the leftmost pixel |
| dispRow | input | 5 | Row selected on the display port |
| dispData | output | 64 | Selected row, bit c is column c |
| busy | output | 1 | A draw is in progress |
| done | output | 1 | One-cycle completion strobe |
| collision | output | 1 | A lit pixel was cleared by this draw, valid with done |

## Verification
Sprites are drawn first onto an empty buffer and then over themselves. This separates XOR from OR or overwrite, because only XOR erases and flags collision. Positions near the right and bottom edges, and coordinates of 64 or more, show whether wrapping happens per column and per row or whether writes spill into a neighbouring row. Memory latencies of 0 to 3 cycles, with start and clear pulsed mid-draw, show that rows advance only on memValid and that commands arriving while busy change nothing. A 15-row sprite whose addresses cross the top of memory, a zero-height draw and a combined clear and start cover the remaining boundaries.

// File: rtl/blit_pkg.sv
package blit_pkg;
  localparam int FB_W    = 64;
  localparam int FB_H    = 32;
  localparam int SPR_W   = 8;
  localparam int HGT_W   = 4;
  localparam int ADDR_W  = 12;
  localparam int COORD_W = 8;
  localparam int COL_W   = $clog2(FB_W);
  localparam int ROW_W   = $clog2(FB_H);
  localparam int SIDX_W  = $clog2(SPR_W);

  // strobes from control to datapath
  typedef struct packed {
    logic             latchCmd;
    logic             applyRow;
    logic             clearAll;
    logic             finish;
    logic [HGT_W-1:0] rowIdx;
  } blitStrobe_t;
endpackage

// File: rtl/blit_ctrl.sv
module blit_ctrl
  import blit_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             startCmd,
  input  logic             clearCmd,
  input  logic [HGT_W-1:0] height,
  input  logic             memValid,
  output logic             memReq,
  output logic             busy,
  output logic             done,
  output blitStrobe_t      stb
);
  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_FIN} ctrlState_t;
  localparam logic [HGT_W-1:0] ONE = HGT_W'(1);

  ctrlState_t       state;
  logic [HGT_W-1:0] rowIdx;
  logic [HGT_W-1:0] rowsLeft;
  logic             accept;

  assign accept = (state == S_IDLE) && startCmd && !clearCmd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      rowIdx   <= '0;
      rowsLeft <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (accept) begin
          rowIdx   <= '0;
          rowsLeft <= height;
          state    <= (height == '0) ? S_FIN : S_FETCH;
        end
        S_FETCH: if (memValid) begin
          if (rowIdx == rowsLeft - ONE) state <= S_FIN;
          else rowIdx <= rowIdx + ONE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    memReq       = (state == S_FETCH);
    busy         = (state != S_IDLE);
    done         = (state == S_FIN);
    stb.latchCmd = accept;
    stb.applyRow = (state == S_FETCH) && memValid;
    stb.clearAll = (state == S_IDLE) && clearCmd;
    stb.finish   = (state == S_FIN);
    stb.rowIdx   = rowIdx;
  end

  // R2: completion only while busy, and for one cycle
  p_done_busy_r2: assert property (@(posedge clk) disable iff (!rstN) done |-> busy);
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rstN) done |=> !done);
  // R3: a pending request keeps its row until the byte arrives
  p_row_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memValid) |=> (memReq && $stable(stb.rowIdx)));
  // R8: zero height finishes directly
  p_zero_height_r8: assert property (@(posedge clk) disable iff (!rstN)
    (stb.latchCmd && height == '0) |=> (done && !memReq));
  // R9: a busy block takes no new command
  p_no_restart_r9: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !stb.latchCmd);
endmodule

// File: rtl/blit_datapath.sv
module blit_datapath
  import blit_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  blitStrobe_t        stb,
  input  logic [COORD_W-1:0] posX,
  input  logic [COORD_W-1:0] posY,
  input  logic [ADDR_W-1:0]  baseAddr,
  input  logic [SPR_W-1:0]   memData,
  input  logic [ROW_W-1:0]   dispRow,
  output logic [ADDR_W-1:0]  memAddr,
  output logic [FB_W-1:0]    dispData,
  output logic               collision
);
  logic [FB_H-1:0][FB_W-1:0] fbRows;
  logic [COL_W-1:0]          xReg;
  logic [ROW_W-1:0]          yReg;
  logic [ADDR_W-1:0]         baseReg;
  logic                      collAcc;
  logic [ROW_W-1:0]          targetRow;
  logic [FB_W-1:0]           curRow;
  logic [FB_W-1:0]           rowMask;

  assign targetRow = yReg + ROW_W'(stb.rowIdx);
  assign curRow    = fbRows[targetRow];

  // per-column decode of the shifted, wrapped sprite byte
  for (genvar c = 0; c < FB_W; c++) begin : g_col
    logic [COL_W-1:0] offs;
    assign offs = COL_W'(c) - xReg;
    assign rowMask[c] = (offs < COL_W'(SPR_W)) &&
                        memData[SIDX_W'(SPR_W-1) - offs[SIDX_W-1:0]];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fbRows  <= '0;
      xReg    <= '0;
      yReg    <= '0;
      baseReg <= '0;
      collAcc <= 1'b0;
    end else begin
      if (stb.clearAll) fbRows <= '0;
      if (stb.latchCmd) begin
        xReg    <= posX[COL_W-1:0];
        yReg    <= posY[ROW_W-1:0];
        baseReg <= baseAddr;
        collAcc <= 1'b0;
      end
      if (stb.applyRow) begin
        fbRows[targetRow] <= curRow ^ rowMask;
        if (|(curRow & rowMask)) collAcc <= 1'b1;
      end
    end
  end

  assign memAddr   = baseReg + ADDR_W'(stb.rowIdx);
  assign dispData  = fbRows[dispRow];
  assign collision = stb.finish && collAcc;

  // R10: a clear empties the buffer on the next cycle
  p_clear_all_r10: assert property (@(posedge clk) disable iff (!rstN)
    stb.clearAll |=> (fbRows == '0));
  // R7: collision is only reported in the done cycle
  p_coll_gate_r7: assert property (@(posedge clk) disable iff (!rstN)
    collision |-> stb.finish);
  // R7: once seen, a collision is kept until the next command
  p_coll_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    (collAcc && !stb.latchCmd) |=> collAcc);
  // R4: rows the sprite does not touch stay unchanged
  p_idle_stable_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.applyRow && !stb.clearAll) |=> $stable(fbRows));
endmodule

// File: rtl/sprite_blitter.sv
module sprite_blitter
  import blit_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               startCmd,
  input  logic               clearCmd,
  input  logic [COORD_W-1:0] posX,
  input  logic [COORD_W-1:0] posY,
  input  logic [HGT_W-1:0]   height,
  input  logic [ADDR_W-1:0]  baseAddr,
  output logic               memReq,
  output logic [ADDR_W-1:0]  memAddr,
  input  logic               memValid,
  input  logic [SPR_W-1:0]   memData,
  input  logic [ROW_W-1:0]   dispRow,
  output logic [FB_W-1:0]    dispData,
  output logic               busy,
  output logic               done,
  output logic               collision
);
  blitStrobe_t stb;

  blit_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startCmd(startCmd), .clearCmd(clearCmd),
    .height(height), .memValid(memValid), .memReq(memReq),
    .busy(busy), .done(done), .stb(stb)
  );

  blit_datapath u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .posX(posX), .posY(posY),
    .baseAddr(baseAddr), .memData(memData), .dispRow(dispRow),
    .memAddr(memAddr), .dispData(dispData), .collision(collision)
  );

  // R3: requests only during a draw
  p_req_busy_r3: assert property (@(posedge clk) disable iff (!rstN) memReq |-> busy);
  // R3: address holds while the request is pending
  p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memValid) |=> $stable(memAddr));
endmodule

// File: tb/sprite_blitter_tb.sv
module sprite_blitter_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startCmd = 1'b0, clearCmd = 1'b0;
  logic [7:0]  posX = '0, posY = '0;
  logic [3:0]  height = '0;
  logic [11:0] baseAddr = '0;
  logic        memReq;
  logic [11:0] memAddr;
  logic        memValid = 1'b0;
  logic [7:0]  memData = '0;
  logic [4:0]  dispRow = '0;
  logic [63:0] dispData;
  logic        busy, done, collision;

  always #2 clk = ~clk;

  sprite_blitter u_dut (
    .clk(clk), .rstN(rstN), .startCmd(startCmd), .clearCmd(clearCmd),
    .posX(posX), .posY(posY), .height(height), .baseAddr(baseAddr),
    .memReq(memReq), .memAddr(memAddr), .memValid(memValid), .memData(memData),
    .dispRow(dispRow), .dispData(dispData), .busy(busy), .done(done),
    .collision(collision)
  );

  int total = 0, bad = 0, cyc = 0;
  int memLat = 0, waitCnt = 0;
  logic [7:0]  mem [4096];
  logic [63:0] refFb [32];
  logic [63:0] dutRows [32];
  int mSt = 0, mRow = 0, mH = 0, mX = 0, mY = 0, mBase = 0;
  bit mColl = 0;
  bit lastColl;
  int lastCycles;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // behavioural reference, advanced on each rising edge
  always @(posedge clk) begin
    cyc++;
    if (!rstN) begin
      mSt = 0; mRow = 0; mColl = 0;
      for (int r = 0; r < 32; r++) refFb[r] = '0;
    end else begin
      case (mSt)
        0: if (clearCmd) begin
             for (int r = 0; r < 32; r++) refFb[r] = '0;
           end else if (startCmd) begin
             mX = posX % 64; mY = posY % 32; mH = height; mBase = baseAddr;
             mColl = 0; mRow = 0;
             mSt = (height == 0) ? 2 : 1;
           end
        1: if (memValid) begin
             for (int k = 0; k < 8; k++) begin
               if (memData[7-k]) begin
                 int col, row;
                 col = (mX + k) % 64;
                 row = (mY + mRow) % 32;
                 if (refFb[row][col]) mColl = 1;
                 refFb[row][col] = ~refFb[row][col];
               end
             end
             mRow++;
             if (mRow == mH) mSt = 2;
           end
        default: mSt = 0;
      endcase
    end
    if (cyc > 60000) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=<60000", cyc);
      finishRun();
    end
  end

  // memory responder with programmable latency
  always @(negedge clk) begin
    if (memReq && waitCnt >= memLat) begin
      memValid = 1'b1;
      memData  = mem[memAddr];
      waitCnt  = 0;
    end else begin
      memValid = 1'b0;
      if (memReq) waitCnt++;
    end
  end

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (rstN) begin
      dispRow = 5'(cyc % 32);
      #1;
      chk(busy === (mSt != 0), "R2 busy", 64'(busy), 64'(mSt != 0));
      chk(done === (mSt == 2), "R2 done", 64'(done), 64'(mSt == 2));
      chk(memReq === (mSt == 1), "R3 memReq", 64'(memReq), 64'(mSt == 1));
      if (mSt == 1)
        chk(memAddr === 12'((mBase + mRow) % 4096), "R3 memAddr", 64'(memAddr), 64'((mBase + mRow) % 4096));
      chk(collision === (mSt == 2 && mColl), "R7 collision", 64'(collision), 64'(mSt == 2 && mColl));
      chk(dispData === refFb[dispRow], "R11 R4 dispData row", dispData, refFb[dispRow]);
      dutRows[dispRow] = dispData;
    end
  end

  task automatic draw(input int x, input int y, input int h, input int base, input bit intrude);
    @(negedge clk);
    posX = 8'(x); posY = 8'(y); height = 4'(h); baseAddr = 12'(base);
    startCmd = 1'b1;
    @(negedge clk);
    startCmd = 1'b0;
    lastCycles = 1;
    if (intrude) begin
      // R9 R10: commands while busy must be ignored
      startCmd = 1'b1; clearCmd = 1'b1;
      posX = 8'd0; posY = 8'd0; height = 4'd2; baseAddr = 12'h100;
      @(negedge clk);
      startCmd = 1'b0; clearCmd = 1'b0;
      lastCycles++;
    end
    while (!done && lastCycles < 300) begin
      @(negedge clk);
      lastCycles++;
    end
    lastColl = collision;
  endtask

  task automatic settle();
    repeat (34) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 8'((i * 37 + 11) % 256);
    mem[12'h100] = 8'hF0; mem[12'h101] = 8'h81; mem[12'h102] = 8'hFF;
    for (int i = 0; i < 4; i++) mem[12'h200 + i] = 8'hFF;
    mem[12'h300] = 8'hFF; mem[12'h301] = 8'h0F;
    mem[12'h310] = 8'h01; mem[12'h311] = 8'h80;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    chk(!busy && !done && !collision && !memReq, "R1 reset outputs", {busy, done, collision, memReq}, 0);
    settle();
    for (int r = 0; r < 32; r++) chk(dutRows[r] == 0, "R1 reset buffer", dutRows[r], 0);

    // R4 R2: basic draw, memory answers at once
    memLat = 0;
    draw(0, 0, 3, 12'h100, 0);
    chk(lastCycles == 4, "R2 done timing", lastCycles, 4);
    chk(!lastColl, "R7 no collision on empty", lastColl, 0);
    settle();
    chk(dutRows[0] == 64'h0F, "R4 row0", dutRows[0], 64'h0F);
    chk(dutRows[1] == 64'h81, "R4 row1", dutRows[1], 64'h81);
    chk(dutRows[2] == 64'hFF, "R4 row2", dutRows[2], 64'hFF);

    // R12: same sprite again erases it
    draw(0, 0, 3, 12'h100, 0);
    chk(lastColl, "R12 collision on redraw", lastColl, 1);
    settle();
    for (int r = 0; r < 3; r++) chk(dutRows[r] == 0, "R12 erased", dutRows[r], 0);

    // R5 R6: wrap at the right and bottom edges, latency 2
    memLat = 2;
    draw(60, 30, 4, 12'h200, 0);
    chk(!lastColl, "R7 wrap no collision", lastColl, 0);
    settle();
    chk(dutRows[30] == 64'hF00000000000000F, "R5 row30", dutRows[30], 64'hF00000000000000F);
    chk(dutRows[31] == 64'hF00000000000000F, "R6 row31", dutRows[31], 64'hF00000000000000F);
    chk(dutRows[0] == 64'hF00000000000000F, "R6 row0", dutRows[0], 64'hF00000000000000F);
    chk(dutRows[1] == 64'hF00000000000000F, "R6 row1", dutRows[1], 64'hF00000000000000F);
    chk(dutRows[2] == 0, "R6 row2 untouched", dutRows[2], 0);

    // R5 R6: coordinates beyond the screen are reduced
    memLat = 1;
    draw(200, 70, 1, 12'h300, 0);
    settle();
    chk(dutRows[6] == 64'hFF00, "R5 R6 modulo position", dutRows[6], 64'hFF00);

    // R8: zero height
    draw(3, 3, 0, 12'h300, 0);
    chk(lastCycles == 1, "R8 immediate done", lastCycles, 1);
    settle();
    chk(dutRows[6] == 64'hFF00, "R8 buffer unchanged", dutRows[6], 64'hFF00);

    // R9 R10 R7: intruding commands during a slow fetch
    memLat = 3;
    draw(8, 6, 1, 12'h301, 1);
    chk(lastColl, "R7 partial collision", lastColl, 1);
    settle();
    chk(dutRows[6] == 64'h0F00, "R9 draw unaffected", dutRows[6], 64'h0F00);
    chk(dutRows[30] == 64'hF00000000000000F, "R10 clear while busy ignored", dutRows[30], 64'hF00000000000000F);

    // R10: clear together with start
    @(negedge clk);
    clearCmd = 1'b1; startCmd = 1'b1; height = 4'd1; baseAddr = 12'h300;
    @(negedge clk);
    clearCmd = 1'b0; startCmd = 1'b0;
    #1;
    chk(!busy, "R10 start ignored under clear", busy, 0);
    settle();
    for (int r = 0; r < 32; r++) chk(dutRows[r] == 0, "R10 cleared", dutRows[r], 0);

    // R3 R12: tallest sprite with address wrap
    memLat = 1;
    draw(0, 20, 15, 12'hFFA, 0);
    chk(!lastColl, "R7 tall empty", lastColl, 0);
    draw(0, 20, 15, 12'hFFA, 0);
    chk(lastColl, "R12 tall redraw", lastColl, 1);
    settle();
    for (int r = 0; r < 32; r++) chk(dutRows[r] == 0, "R12 tall erased", dutRows[r], 0);

    // R7: single-pixel overlap versus a neighbour
    memLat = 0;
    draw(5, 3, 1, 12'h310, 0);
    draw(13, 3, 1, 12'h311, 0);
    chk(!lastColl, "R7 adjacent no collision", lastColl, 0);
    draw(12, 3, 1, 12'h311, 0);
    chk(lastColl, "R7 single overlap", lastColl, 1);
    settle();
    chk(dutRows[3] == 64'h2000, "R4 single overlap result", dutRows[3], 64'h2000);

    finishRun();
  end
endmodule